// File: doc/BRIEF.md
# I2C Bus Stall Watchdog

This block watches an I2C controller for a transfer that has stopped making progress. A free-running up-counter advances while the watchdog is switched on and the controller's status flag is low. In that state the controller is busy and is not waiting on software. Any sign of bus progress puts the counter back to zero. That means a falling edge on the bus clock line, a detected STOP condition, or the status flag rising. If the counter overflows, a sticky time-out flag is raised for software to see.

The clock line comes in raw and is synchronised inside the block before edges are detected. STOP detection and the status flag come in already produced by the protocol engine. A slow mode makes the counter advance once every four system clocks, so the time-out period becomes four times longer. Software clears the flag by pulsing a write-one-to-clear strobe.

Top module: `bus_stall_watchdog`

## Requirements
- R1: After reset the time-out flag is 0, the count is 0 and the clock-line synchroniser holds the idle-high level.
- R2: With the watchdog enabled, the status flag low and no restart, the 14-bit count rises by one on every clock. The flag is set on the clock edge at which the count wraps from all ones, which is the 16384th advance after a restart.
- R3: When the slow input is 1, the count advances only on every fourth enabled clock, counted from the last restart. The flag is then set on the 65536th clock edge.
- R4: While the status flag is high the count is held at 0. Counting resumes on the first clock after the status flag goes low.
- R5: A high-to-low change on the clock-line input passes through a two-stage synchroniser and then restarts the count. A restarted count overflows 16384 clocks after the third edge following the change. A low-to-high change has no effect.
- R6: A one-cycle STOP pulse restarts the count on that clock edge.
- R7: While the enable input is 0, the count and the divide-by-four prescaler are held at 0. The time-out flag keeps its value.
- R8: Once set, the time-out flag stays at 1, even while the count wraps and starts again, until it is cleared.
- R9: A clear pulse with no overflow in the same cycle makes the flag 0 on the next clock edge.
- R10: If an overflow and a clear pulse fall on the same clock edge, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| wd_enable | input | 1 | 1 = watchdog counting allowed; 0 = count and prescaler held at zero |
| wd_slow | input | 1 | 1 = advance once every four clocks; 0 = every clock |
| scl_raw | input | 1 | Unsynchronised bus clock line level |
| stop_pulse | input | 1 | One-cycle pulse when a STOP condition is detected |
| busy_flag_n | input | 1 | Controller status flag; counting only while this is 0 |
| tout_clear | input | 1 | Write-one-to-clear strobe for the time-out flag |
| tout_flag | output | 1 | Sticky time-out flag |

## Verification
The assertions assume that the STOP input is a clean one-cycle pulse and that the clear strobe is synchronous to the clock. They also assume the enable, slow and status inputs change only between clock edges. The bench drives every input on the falling clock edge, holds the slow select constant for a whole run, and gives the STOP and clear inputs exactly one clock each. The clock-line input is the only one the block treats as asynchronous. It is never checked directly, only through the synchronised falling-edge pulse.

// File: rtl/bstw_pkg.sv
package bstw_pkg;

  localparam int unsigned DEF_CNT_W = 14;
  localparam int unsigned DEF_DIV   = 4;
  localparam int unsigned DEF_SYNC  = 2;

  typedef enum logic {
    TICK_EVERY   = 1'b0,
    TICK_DIVIDED = 1'b1
  } tick_mode_e;

endpackage

// File: rtl/bstw_reset_sync.sv
module bstw_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_ok = stage_q[1];

endmodule

// File: rtl/bstw_scl_edge.sv
module bstw_scl_edge #(
  parameter int unsigned STAGES = bstw_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst_ok,
  input  logic scl_raw,
  output logic scl_fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // shift chain; stage 0 samples the raw line
  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = scl_raw;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], scl_raw};
    end
  endgenerate

  always_comb prev_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign scl_fall = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/bstw_prescaler.sv
module bstw_prescaler #(
  parameter int unsigned DIV = bstw_pkg::DEF_DIV
) (
  input  logic clk,
  input  logic rst_ok,
  input  logic run,
  input  logic restart,
  input  logic slow,
  output logic tick,
  output logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0] phase
);

  import bstw_pkg::*;

  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  tick_mode_e       mode;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             pre_en;

  always_comb begin
    mode = tick_mode_e'(slow);
    tick = (mode == TICK_EVERY) ? 1'b1 : (pre_q == LAST);
  end

  always_comb begin
    pre_en = 1'b1;
    pre_d  = pre_q;
    if (!run || restart || mode == TICK_EVERY) begin
      pre_d = '0;
    end else if (pre_q == LAST) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

  assign phase = pre_q;

endmodule

// File: rtl/bstw_counter.sv
module bstw_counter #(
  parameter int unsigned CNT_W = bstw_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    wrap   = 1'b0;
    if (!run || restart) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
      wrap   = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog #(
  parameter int unsigned CNT_W = bstw_pkg::DEF_CNT_W,
  parameter int unsigned DIV   = bstw_pkg::DEF_DIV,
  parameter int unsigned SYNC  = bstw_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_enable,
  input  logic wd_slow,
  input  logic scl_raw,
  input  logic stop_pulse,
  input  logic busy_flag_n,
  input  logic tout_clear,
  output logic tout_flag
);

  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic             rst_ok;
  logic             scl_fall;
  logic             restart;
  logic             tick;
  logic [PRE_W-1:0] phase;
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             flag_q;
  logic             flag_d;

  bstw_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  bstw_scl_edge #(.STAGES(SYNC)) u_edge (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .scl_raw  (scl_raw),
    .scl_fall (scl_fall)
  );

  // any sign of bus progress, or the controller waiting on software
  always_comb restart = busy_flag_n | scl_fall | stop_pulse;

  bstw_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .run     (wd_enable),
    .restart (restart),
    .slow    (wd_slow),
    .tick    (tick),
    .phase   (phase)
  );

  bstw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .run     (wd_enable),
    .restart (restart),
    .tick    (tick),
    .count   (count),
    .wrap    (wrap)
  );

  // set has priority over clear
  always_comb begin
    flag_d = flag_q;
    if (wrap) begin
      flag_d = 1'b1;
    end else if (tout_clear) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign tout_flag = flag_q;

endmodule

// File: rtl/bstw_checker.sv
module bstw_checker #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned PRE_W = 2,
  parameter int unsigned DIV   = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             wd_enable,
  input logic             wd_slow,
  input logic             busy_flag_n,
  input logic             stop_pulse,
  input logic             tout_clear,
  input logic             scl_fall,
  input logic [CNT_W-1:0] count,
  input logic [PRE_W-1:0] phase,
  input logic             wrap,
  input logic             tout_flag
);

  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  // R2: plain counting steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (wd_enable && !wd_slow && !busy_flag_n && !stop_pulse && !scl_fall)
      |=> (count == CNT_W'($past(count) + CNT_W'(1))));

  // R3: in slow mode the count is still between ticks
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_ok)
    (wd_enable && wd_slow && !busy_flag_n && !stop_pulse && !scl_fall && phase != LAST)
      |=> $stable(count));

  // R4
  a_r4_busy_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    busy_flag_n |=> (count == '0));

  // R5
  a_r5_fall_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    scl_fall |=> (count == '0));

  a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_ok)
    scl_fall |=> !scl_fall);

  // R6
  a_r6_stop_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    stop_pulse |=> (count == '0));

  // R7
  a_r7_off_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    !wd_enable |=> (count == '0 && phase == '0));

  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    (tout_flag && !tout_clear) |=> tout_flag);

  // R9
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    (tout_clear && !wrap) |=> !tout_flag);

  // R10
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    wrap |=> tout_flag);

endmodule

bind bus_stall_watchdog bstw_checker #(
  .CNT_W (CNT_W),
  .PRE_W (PRE_W),
  .DIV   (DIV)
) u_chk (
  .clk         (clk),
  .rst_ok      (rst_ok),
  .wd_enable   (wd_enable),
  .wd_slow     (wd_slow),
  .busy_flag_n (busy_flag_n),
  .stop_pulse  (stop_pulse),
  .tout_clear  (tout_clear),
  .scl_fall    (scl_fall),
  .count       (count),
  .phase       (phase),
  .wrap        (wrap),
  .tout_flag   (tout_flag)
);

// File: tb/sim_bus_stall_watchdog.sv
module sim_bus_stall_watchdog;

  localparam int FULL     = 16384;
  localparam int WD_LIMIT = 195000;

  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_STOP = 3'd1;
  localparam logic [2:0] K_SCL  = 3'd2;
  localparam logic [2:0] K_BUSY = 3'd3;
  localparam logic [2:0] K_OFF  = 3'd4;

  typedef struct packed {
    logic [2:0]  kind;
    logic        slow;
    logic        ext;
    logic [15:0] lead;
    logic [15:0] hold;
    logic [31:0] fire;   // edge on which the flag must first read 1
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{K_NONE, 1'b0, 1'b1, 16'd0,   16'd0,  32'(FULL)},
    '{K_STOP, 1'b0, 1'b0, 16'd100, 16'd0,  32'(100 + 1 + FULL)},
    '{K_SCL,  1'b0, 1'b0, 16'd50,  16'd0,  32'(50 + 3 + FULL)},
    '{K_BUSY, 1'b0, 1'b0, 16'd30,  16'd20, 32'(30 + 20 + FULL)},
    '{K_OFF,  1'b0, 1'b0, 16'd40,  16'd0,  32'(40 + 1 + FULL)},
    '{K_NONE, 1'b1, 1'b0, 16'd0,   16'd0,  32'(4 * FULL)}
  };

  logic clk;
  logic rst_n;
  logic wd_enable;
  logic wd_slow;
  logic scl_raw;
  logic stop_pulse;
  logic busy_flag_n;
  logic tout_clear;
  logic tout_flag;

  int n_checks;
  int n_fail;
  int cycles;

  bus_stall_watchdog u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_enable   (wd_enable),
    .wd_slow     (wd_slow),
    .scl_raw     (scl_raw),
    .stop_pulse  (stop_pulse),
    .busy_flag_n (busy_flag_n),
    .tout_clear  (tout_clear),
    .tout_flag   (tout_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string req_of(input logic [2:0] kind, input logic slow);
    if (slow) return "R3";
    case (kind)
      K_STOP:  return "R6";
      K_SCL:   return "R5";
      K_BUSY:  return "R4";
      K_OFF:   return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input int edge_no);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: tout_flag actual=%b expected=%b", req, edge_no, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n       = 1'b0;
    wd_enable   = 1'b0;
    wd_slow     = 1'b0;
    scl_raw     = 1'b1;
    stop_pulse  = 1'b0;
    busy_flag_n = 1'b0;
    tout_clear  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WD_LIMIT) begin
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: run actual=unfinished expected=finished");
        finish_run();
      end
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;

    do_reset();
    check("R1", tout_flag, 1'b0, 0);

    for (int v = 0; v < NV; v++) begin
      int fire;
      int lead;
      int hold;
      int last;
      string req;
      do_reset();
      fire    = int'(VECS[v].fire);
      lead    = int'(VECS[v].lead);
      hold    = int'(VECS[v].hold);
      last    = VECS[v].ext ? 2 * fire + 1 : fire;
      req     = req_of(VECS[v].kind, VECS[v].slow);
      wd_slow = VECS[v].slow;
      for (int e = 1; e <= last; e++) begin
        wd_enable   = !(VECS[v].kind == K_OFF && e == lead + 1);
        stop_pulse  = (VECS[v].kind == K_STOP && e == lead + 1);
        busy_flag_n = (VECS[v].kind == K_BUSY && e > lead && e <= lead + hold);
        // low from lead+1; rising again at lead+41 must not restart (R5)
        scl_raw     = !(VECS[v].kind == K_SCL && e > lead && e <= lead + 40);
        tout_clear  = VECS[v].ext && (e == 2 * fire || e == 2 * fire + 1);
        @(posedge clk);
        @(negedge clk);
        if (e == fire - 1) check(req, tout_flag, 1'b0, e);
        if (e == fire)     check(req, tout_flag, 1'b1, e);
        if (VECS[v].ext) begin
          if (e == 2 * fire - 1) check("R8",  tout_flag, 1'b1, e);
          if (e == 2 * fire)     check("R10", tout_flag, 1'b1, e);
          if (e == 2 * fire + 1) check("R9",  tout_flag, 1'b0, e);
        end
      end
    end

    finish_run();
  end

endmodule